// File: doc/BRIEF.md
# Bus Node Fault Confinement Counters

This unit holds the transmit and receive error counters of a serial bus node. From them it derives whether the node is error active, error passive or bus off. The protocol engine drives it with single-cycle event pulses. The pulses report:

- errors found while receiving or transmitting,
- a dominant bit seen right after the node's own error flag,
- bit errors while the node sends an active error flag or an overload flag,
- each further run of eight dominant bits,
- successful transmissions and successful receptions.

Two qualifier inputs mark the cases in which a transmit error leaves the transmit counter unchanged. A third qualifier marks the receive error that is exempt from the +1 step. A role input tells the unit which counter the role-dependent events charge.

Several events that arrive in the same cycle have their steps added together. Both counters are 9 bits wide and saturate at 511. Once the transmit counter passes 255, the node is bus off. It stays there, with both counters frozen, until a restart request clears it. The unit also raises a warning level when either counter reaches 96, and it emits a one-cycle interrupt pulse on two occasions: when the warning rises (if enabled) and when the node enters bus off.

Top module: `fault_confine`

## Requirements
- R1: `state` reads 0 (error active) while neither counter exceeds 127 and the node is not bus off.
- R2: `state` reads 1 (error passive) when at least one counter exceeds 127 and the node is not bus off.
- R3: When the transmit counter passes 255, `state` reads 2 and `busoff` is high. While bus off, every event input is ignored and both counters hold. Only `restart` leaves bus off, and it clears both counters to 0.
- R4: `rx_err` adds 1 to the receive counter, unless `rx_err_in_flag` is high in the same cycle.
- R5: `dom_after_flag` adds 8 to the receive counter. `tx_err` adds 8 to the transmit counter.
- R6: `tx_err` leaves the transmit counter unchanged when `exc_ack_passive` or `exc_arb_stuff` is high in the same cycle.
- R7: `flag_bit_err` and `dom_run8` each add 8 to the transmit counter when `role_tx` is 1, and to the receive counter when `role_tx` is 0.
- R8: `tx_ok` subtracts 1 from the transmit counter, and leaves it at 0 when it is already 0.
- R9: `rx_ok` applies one of three rules to the receive counter: it subtracts 1 when the counter is between 1 and 127, it keeps 0 at 0, and it loads 127 when the counter is above 127.
- R10: `warn` is high while either counter is 96 or more. A low-to-high change of `warn` gives a one-cycle `irq` pulse only when `irq_en` is high.
- R11: Entry to bus off gives a one-cycle `irq` pulse regardless of `irq_en`.
- R12: All steps that apply in one cycle are summed into a single update. Each counter saturates at 511 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Request to clear counters and leave bus off |
| irq_en | input | 1 | Enables the warning interrupt |
| role_tx | input | 1 | 1 when the node is the transmitter of the current frame |
| rx_err | input | 1 | Error detected, receive-counter step |
| rx_err_in_flag | input | 1 | Qualifies rx_err as a bit error during own active flag |
| dom_after_flag | input | 1 | Dominant bit seen first after own error flag |
| tx_err | input | 1 | Transmitter sends an error flag |
| exc_ack_passive | input | 1 | Passive ACK-error exception for tx_err |
| exc_arb_stuff | input | 1 | Arbitration stuff-error exception for tx_err |
| flag_bit_err | input | 1 | Bit error while sending active error or overload flag |
| dom_run8 | input | 1 | One further run of eight dominant bits past the tolerance |
| tx_ok | input | 1 | Frame transmitted successfully |
| rx_ok | input | 1 | Frame received successfully |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| state | output | 2 | 0 active, 1 passive, 2 bus off |
| warn | output | 1 | Either counter at 96 or more |
| busoff | output | 1 | Node is bus off |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every event pulse is sampled at one rising edge. The counters, `state`, `warn` and `busoff` then show the result straight after that edge, with one register in the path. An `irq` pulse sits in that same cycle and is gone by the next one. The bench changes inputs on the falling edge, holds each pulse for one cycle, and reads every output at the next falling edge. Each result is therefore checked exactly one cycle after its stimulus. A second read one cycle later shows that `irq` has dropped.

// File: rtl/fault_confine.sv
module fault_confine #(
  parameter int W        = 9,
  parameter int STEP     = 8,
  parameter int LIM_PASS = 127,
  parameter int LIM_OFF  = 255,
  parameter int WARN_LVL = 96,
  parameter int RELOAD   = 127
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         irq_en,
  input  logic         role_tx,
  input  logic         rx_err,
  input  logic         rx_err_in_flag,
  input  logic         dom_after_flag,
  input  logic         tx_err,
  input  logic         exc_ack_passive,
  input  logic         exc_arb_stuff,
  input  logic         flag_bit_err,
  input  logic         dom_run8,
  input  logic         tx_ok,
  input  logic         rx_ok,
  output logic [W-1:0] tec,
  output logic [W-1:0] rec,
  output logic [1:0]   state,
  output logic         warn,
  output logic         busoff,
  output logic         irq
);
  localparam int SW = W + 3;
  localparam logic [SW-1:0] MAXV = SW'((1 << W) - 1);
  localparam logic [W-1:0]  ONE  = 1;
  localparam logic [SW-1:0] S8   = SW'(STEP);
  localparam logic [SW-1:0] S1   = 1;

  logic [SW-1:0] tec_add, rec_add, tec_sum, rec_sum;
  logic [W-1:0]  tec_base, rec_base, tec_nxt, rec_nxt;
  logic          warn_nxt, boff_nxt;

  always_comb begin
    tec_add = ((tx_err && !exc_ack_passive && !exc_arb_stuff) ? S8 : '0)
            + ((role_tx && flag_bit_err) ? S8 : '0)
            + ((role_tx && dom_run8) ? S8 : '0);
    rec_add = ((rx_err && !rx_err_in_flag) ? S1 : '0)
            + (dom_after_flag ? S8 : '0)
            + ((!role_tx && flag_bit_err) ? S8 : '0)
            + ((!role_tx && dom_run8) ? S8 : '0);
  end

  assign tec_base = (tx_ok && tec != '0) ? tec - ONE : tec;
  assign rec_base = !rx_ok ? rec
                  : (rec > W'(LIM_PASS)) ? W'(RELOAD)
                  : (rec != '0) ? rec - ONE : rec;

  assign tec_sum = SW'(tec_base) + tec_add;
  assign rec_sum = SW'(rec_base) + rec_add;
  assign tec_nxt = (tec_sum > MAXV) ? MAXV[W-1:0] : tec_sum[W-1:0];
  assign rec_nxt = (rec_sum > MAXV) ? MAXV[W-1:0] : rec_sum[W-1:0];

  assign warn     = (tec >= W'(WARN_LVL)) || (rec >= W'(WARN_LVL));
  assign warn_nxt = (tec_nxt >= W'(WARN_LVL)) || (rec_nxt >= W'(WARN_LVL));
  assign boff_nxt = tec_nxt > W'(LIM_OFF);

  assign state = busoff ? 2'd2
               : ((tec > W'(LIM_PASS)) || (rec > W'(LIM_PASS))) ? 2'd1 : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec <= '0; rec <= '0; busoff <= 1'b0; irq <= 1'b0;
    end else if (restart) begin
      tec <= '0; rec <= '0; busoff <= 1'b0; irq <= 1'b0;
    end else if (!busoff) begin
      tec    <= tec_nxt;
      rec    <= rec_nxt;
      busoff <= boff_nxt;
      irq    <= boff_nxt || (irq_en && warn_nxt && !warn);
    end else begin
      irq <= 1'b0;
    end
  end

  p_busoff_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busoff && !restart |=> busoff && tec == $past(tec) && rec == $past(rec));

  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> tec == '0 && rec == '0 && !busoff && state == 2'd0);

  p_tx_ok_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busoff && !restart && tx_ok && !tx_err && !(role_tx && (flag_bit_err || dom_run8))
      && tec != '0 |=> tec == $past(tec) - ONE);

  p_rx_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busoff && !restart && rx_ok && rec > W'(LIM_PASS) && !rx_err && !dom_after_flag
      && !(!role_tx && (flag_bit_err || dom_run8)) |=> rec == W'(RELOAD));

  p_busoff_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff) |-> irq);

  p_rec_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busoff && !restart && !rx_ok |=> rec >= $past(rec));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq || restart || $past(restart) || busoff == 1'b0);
endmodule

// File: tb/fault_confine_test.sv
`timescale 1ns/1ps
module fault_confine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] ev = '0;
  logic [8:0] tec, rec;
  logic [1:0] state;
  logic warn, busoff, irq;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  localparam logic [12:0] RESTART = 13'h1000, IRQEN = 13'h0800, ROLETX = 13'h0400,
    RXERR = 13'h0200, INFLAG = 13'h0100, DOMAFT = 13'h0080, TXERR = 13'h0040,
    EXACK = 13'h0020, EXARB = 13'h0010, FLBIT = 13'h0008, DOMRUN = 13'h0004,
    TXOK = 13'h0002, RXOK = 13'h0001;

  fault_confine uut (
    .clk(clk), .rst_n(rst_n), .restart(ev[12]), .irq_en(ev[11]), .role_tx(ev[10]),
    .rx_err(ev[9]), .rx_err_in_flag(ev[8]), .dom_after_flag(ev[7]), .tx_err(ev[6]),
    .exc_ack_passive(ev[5]), .exc_arb_stuff(ev[4]), .flag_bit_err(ev[3]),
    .dom_run8(ev[2]), .tx_ok(ev[1]), .rx_ok(ev[0]),
    .tec(tec), .rec(rec), .state(state), .warn(warn), .busoff(busoff), .irq(irq));

  localparam int NV = 17;
  localparam logic [34:0] VEC [NV] = '{
    {4'd4,  RXERR,                         9'd0,  9'd1},   // R4
    {4'd4,  RXERR | INFLAG,                9'd0,  9'd1},   // R4 exempt
    {4'd5,  DOMAFT,                        9'd0,  9'd9},   // R5
    {4'd5,  TXERR,                         9'd8,  9'd9},   // R5
    {4'd6,  TXERR | EXACK,                 9'd8,  9'd9},   // R6
    {4'd6,  TXERR | EXARB,                 9'd8,  9'd9},   // R6
    {4'd7,  ROLETX | FLBIT,                9'd16, 9'd9},   // R7
    {4'd7,  FLBIT,                         9'd16, 9'd17},  // R7
    {4'd7,  ROLETX | DOMRUN,               9'd24, 9'd17},  // R7
    {4'd7,  DOMRUN,                        9'd24, 9'd25},  // R7
    {4'd8,  TXOK,                          9'd23, 9'd25},  // R8
    {4'd9,  RXOK,                          9'd23, 9'd24},  // R9
    {4'd12, RXERR | DOMAFT | FLBIT | DOMRUN, 9'd23, 9'd49}, // R12
    {4'd12, ROLETX | TXERR | FLBIT | DOMRUN, 9'd47, 9'd49}, // R12
    {4'd3,  RESTART,                       9'd0,  9'd0},   // R3
    {4'd8,  TXOK,                          9'd0,  9'd0},   // R8 floor
    {4'd9,  RXOK,                          9'd0,  9'd0}    // R9 floor
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [12:0] e);
    @(negedge clk);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset tec", tec, 0);
    chk("R1 reset rec", rec, 0);
    chk("R1 reset state", state, 0);
    chk("R10 reset warn", warn, 0);
    chk("R3 reset busoff", busoff, 0);
    chk("R11 reset irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:18]);
      checks++;
      if (tec != VEC[i][17:9] || rec != VEC[i][8:0]) begin
        errors++;
        $display("FAIL table row %0d R%0d: actual tec=%0d rec=%0d expected tec=%0d rec=%0d",
                 i, VEC[i][34:31], tec, rec, VEC[i][17:9], VEC[i][8:0]);
      end
    end

    // R10 warning with interrupt enabled
    for (int i = 0; i < 11; i++) apply(IRQEN | DOMAFT);
    chk("R10 rec 88", rec, 88);
    chk("R10 warn below", warn, 0);
    apply(IRQEN | DOMAFT);
    chk("R10 warn at 96", warn, 1);
    chk("R10 irq on warn", irq, 1);
    apply(IRQEN);
    chk("R10 irq one cycle", irq, 0);
    for (int i = 0; i < 5; i++) apply(DOMAFT);
    chk("R2 rec 136", rec, 136);
    chk("R2 passive", state, 1);
    apply(RXOK);
    chk("R9 reload", rec, 127);
    chk("R1 active at 127", state, 0);

    // R11 bus off, warning interrupt gated by irq_en
    apply(RESTART);
    chk("R3 restart rec", rec, 0);
    for (int i = 0; i < 12; i++) apply(TXERR);
    chk("R10 tec 96 warn", warn, 1);
    chk("R10 irq gated", irq, 0);
    for (int i = 0; i < 4; i++) apply(TXERR);
    chk("R2 tec 128", state, 1);
    for (int i = 0; i < 15; i++) apply(TXERR);
    chk("R2 tec 248", tec, 248);
    chk("R2 still passive", state, 1);
    apply(TXERR);
    chk("R3 tec 256", tec, 256);
    chk("R3 state busoff", state, 2);
    chk("R3 busoff flag", busoff, 1);
    chk("R11 irq on busoff", irq, 1);
    apply(TXOK | RXERR | DOMAFT);
    chk("R3 frozen tec", tec, 256);
    chk("R3 frozen rec", rec, 0);
    chk("R11 irq one cycle", irq, 0);
    chk("R3 still busoff", busoff, 1);
    apply(RESTART);
    chk("R3 left busoff", busoff, 0);
    chk("R3 cleared tec", tec, 0);
    chk("R1 active after restart", state, 0);

    // R12 saturation
    for (int i = 0; i < 63; i++) apply(DOMAFT);
    chk("R12 rec 504", rec, 504);
    apply(DOMAFT);
    chk("R12 saturate", rec, 511);
    apply(DOMAFT | RXERR);
    chk("R12 hold at max", rec, 511);
    chk("R2 passive by rec", state, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule